// File: doc/BRIEF.md
# Two-Wire Register Slave with Command-Byte Decode

This block is the bus-facing front end of a small register-mapped peripheral on a two-wire (I2C-compatible) bus. It samples SCL and SDA into the system clock and finds start and stop conditions. It shifts bytes in MSB first and acknowledges each accepted byte during the ninth clock. SDA leaves the block as an open-drain enable: while `sda_oe` is high the pad pulls the line low. While it is low the line is released.

Every transfer opens with a slave-address byte, which is matched against a parameter. A command byte follows and sets four things: a write-enable bit, a bank (clock/calendar or RAM), a 5-bit register index and the transfer direction. Write data leaves the block as register write requests. Read data is fetched one byte ahead through a request interface and shifted out on SDA. In both directions the index steps by one after each data byte, so one transfer can cover a run of registers.

Both register-side interfaces use valid/ready. A write request holds `wr_valid` and its payload unchanged until `wr_ready` is seen. A read request holds `rd_valid`, `rd_bank` and `rd_index` until `rd_ready`. `rd_data` must be valid in the cycle of that handshake. The bus cannot be stalled, so back-pressure ends in one of two ways. A data byte that completes while a write is still pending is refused. A read answer that arrives after the byte has begun to shift out is discarded.

Top module: `cmdbyte_i2c_slave`

## Requirements
- R1: While reset is held and right after it, `sda_oe`, `wr_valid` and `rd_valid` are all low.
- R2: The slave ACKs an address byte whose upper seven bits equal `SLAVE_ADDR` by holding SDA low for the whole ninth clock; address bit 0 is not examined.
- R3: After an address byte that does not match, the slave never pulls SDA low, does not acknowledge, and issues no requests until the next start.
- R4: The command byte is always ACKed. Its fields are: bit 7 = write enable, bit 6 = bank (0 clock/calendar, 1 RAM), bits 5..1 = register index, bit 0 = direction (0 write, 1 read).
- R5: With writes enabled, each data byte is ACKed and issued once on the write interface with the current bank and index. The index then steps by one, modulo 32.
- R6: When command bit 7 is 0, data bytes are still ACKed but no write request is issued.
- R7: In a read, the slave fetches the byte at the current index and shifts it out MSB first, then steps the index. It keeps going while the master ACKs. After a master NACK it releases SDA and ignores the bus until the next start.
- R8: A stop that arrives before a byte is complete discards that byte and returns the slave to idle; the next transfer is served normally.
- R9: A write request holds its valid and payload stable until accepted. A data byte that completes while a write is still pending is NACKed and dropped, and the index does not advance.
- R10: A read request holds until `rd_ready`; `rd_data` is taken in the handshake cycle. If no handshake has occurred before the byte's first bit is launched, that byte goes out as 0xFF.
- R11: A repeated start at any point restarts the protocol with a new address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| wr_valid | output | 1 | Register write request pending |
| wr_ready | input | 1 | Register side accepts the write |
| wr_bank | output | 1 | Write bank: 0 clock/calendar, 1 RAM |
| wr_index | output | 5 | Write register index |
| wr_data | output | 8 | Write data byte |
| rd_valid | output | 1 | Register read request pending |
| rd_ready | input | 1 | Register side answers the read this cycle |
| rd_bank | output | 1 | Read bank: 0 clock/calendar, 1 RAM |
| rd_index | output | 5 | Read register index |
| rd_data | input | 8 | Read data, valid in the handshake cycle |

## Verification
The bench targets runs that cross index 31. A design that fails to wrap the index would write or read past the bank. A stop arriving mid-byte must not act; a design that acted on the partial byte would emit a spurious write. The bench holds back-pressure on both interfaces. A design that dropped or overwrote a pending write, or that advanced the index on a refused byte, would put later data at the wrong register. A late read answer must yield 0xFF. The bench also covers a mismatched address and a repeated start straight from a write into a read. A design that kept driving in either case would corrupt the master's bytes.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;
  localparam int BITS_PER_FRAME = DATA_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_bank,
  output logic [IDX_W-1:0]  wr_index,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_bank,
  output logic [IDX_W-1:0]  rd_index,
  input  logic [DATA_W-1:0] rd_data
);
  localparam logic [3:0] LAST_BIT = 4'(DATA_W);
  localparam logic [3:0] ACK_BIT  = 4'(BITS_PER_FRAME);

  phase_e             st;
  logic [3:0]         cnt;
  logic [DATA_W-1:0]  shreg;
  logic [DATA_W-1:0]  tx;
  logic               wen, bank, rdir, mack;
  logic [IDX_W-1:0]   idx;
  logic               wr_block;

  assign wr_block = wr_valid & ~wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  cnt <= '0;  shreg <= '0;  tx <= '1;
      wen <= 1'b0;  bank <= 1'b0;  rdir <= 1'b0;  mack <= 1'b0;  idx <= '0;
      sda_oe <= 1'b0;
      wr_valid <= 1'b0;  wr_bank <= 1'b0;  wr_index <= '0;  wr_data <= '0;
      rd_valid <= 1'b0;  rd_bank <= 1'b0;  rd_index <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        if (cnt >= LAST_BIT) tx <= rd_data;
      end

      if (start_det) begin
        st <= ST_ADDR;  cnt <= '0;  sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE;  cnt <= '0;  sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < LAST_BIT)       shreg <= {shreg[DATA_W-2:0], sda_in};
          else if (cnt == LAST_BIT) mack <= ~sda_in;
          if (cnt != ACK_BIT) cnt <= cnt + 4'd1;
        end
        if (scl_fall) begin
          if (cnt == LAST_BIT) begin
            case (st)
              ST_ADDR: begin
                if (shreg[7:1] == SLAVE_ADDR) sda_oe <= 1'b1;
                else                          st <= ST_IGNORE;
              end
              ST_CMD: begin
                sda_oe <= 1'b1;
                wen    <= shreg[7];
                bank   <= shreg[6];
                idx    <= shreg[5:1];
                rdir   <= shreg[0];
                if (shreg[0]) begin
                  rd_valid <= 1'b1;  rd_bank <= shreg[6];  rd_index <= shreg[5:1];
                  tx <= '1;
                end
              end
              ST_WDATA: begin
                if (!wr_block) begin
                  sda_oe <= 1'b1;
                  idx    <= idx + 1'b1;
                  if (wen) begin
                    wr_valid <= 1'b1;  wr_bank <= bank;  wr_index <= idx;  wr_data <= shreg;
                  end
                end
              end
              ST_RDATA: begin
                sda_oe   <= 1'b0;
                idx      <= idx + 1'b1;
                rd_valid <= 1'b1;  rd_bank <= bank;  rd_index <= idx + 1'b1;
                tx <= '1;
              end
              default: ;
            endcase
          end else if (cnt == ACK_BIT) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (st)
              ST_ADDR: st <= ST_CMD;
              ST_CMD: begin
                if (rdir) begin st <= ST_RDATA; sda_oe <= ~tx[DATA_W-1]; end
                else            st <= ST_WDATA;
              end
              ST_RDATA: begin
                if (mack) sda_oe <= ~tx[DATA_W-1];
                else      st <= ST_IDLE;
              end
              default: ;
            endcase
          end else if (st == ST_RDATA) begin
            sda_oe <= ~tx[DATA_W-2];
            tx     <= {tx[DATA_W-2:0], 1'b1};
          end
        end
      end
    end
  end

  // R3
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_index) && $stable(wr_bank)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && st == ST_IDLE));

  // R5
  wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> ($past(st) == ST_WDATA));

  // R7
  rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ($past(st) == ST_CMD || $past(st) == ST_RDATA));
endmodule

// File: rtl/cmdbyte_i2c_slave.sv
module cmdbyte_i2c_slave
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_bank,
  output logic [IDX_W-1:0]  wr_index,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_bank,
  output logic [IDX_W-1:0]  rd_index,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 2;

  logic [LINES-1:0] pin_raw, pin_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign pin_raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_raw[g]),
      .dout (pin_s[g])
    );
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (pin_s[1]),
    .sda_s    (pin_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_cmd_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_in   (pin_s[0]),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_bank  (wr_bank),
    .wr_index (wr_index),
    .wr_data  (wr_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_bank  (rd_bank),
    .rd_index (rd_index),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/cmdbyte_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module cmdbyte_i2c_slave_tb_top;
  localparam int H = 10;
  localparam logic [6:0] ADDR = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, wr_valid, wr_bank, rd_valid, rd_bank;
  logic wr_ready = 1'b1, rd_ready = 1'b1;
  logic [4:0] wr_index, rd_index;
  logic [7:0] wr_data, rd_data;

  int n_tests = 0, n_fail = 0;
  int quiet_viol = 0, wr_seen = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;
  logic [13:0] exp_wr[$];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] reg_val(input logic b, input logic [4:0] i);
    return {i, b, 2'b10} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] cmd(input logic we, input logic b, input logic [4:0] i, input logic rd);
    return {we, b, i, rd};
  endfunction

  assign rd_data = reg_val(rd_bank, rd_index);

  cmdbyte_i2c_slave #(.SLAVE_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank), .wr_index(wr_index),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_bank(rd_bank),
    .rd_index(rd_index), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference: every clock, writes handed over must match the expected queue
  always @(negedge clk) begin
    if (quiet && sda_oe) quiet_viol++;
    if (rst_n && wr_valid && wr_ready) begin
      wr_seen++;
      if (exp_wr.size() == 0) chk(1'b0, "R3/R6/R8/R9 unexpected write", {18'd0, wr_bank, wr_index, wr_data}, 32'd0);
      else begin
        logic [13:0] e;
        e = exp_wr.pop_front();
        chk({wr_bank, wr_index, wr_data} == e, "R5 write payload", {18'd0, wr_bank, wr_index, wr_data}, {18'd0, e});
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wt(H/2); sda_m = b; wt(H/2); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wt(H/2); sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H-1); b = sda_bus; wt(1); scl_m = 1'b0;
  endtask

  task automatic start_c();
    wt(H/2); sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wt(H/2); sda_m = 1'b0; wt(H/2); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv(output logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      logic v;
      bit_in(v);
      b[i] = v;
    end
    bit_out(~ack);
  endtask

  task automatic push_wr(input logic b, input logic [4:0] i, input logic [7:0] d);
    exp_wr.push_back({b, i, d});
  endtask

  task automatic drain(input string tag);
    wt(20);
    chk(exp_wr.size() == 0, tag, exp_wr.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL WATCHDOG: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    int base;

    wt(3);
    // R1 during reset
    chk(!sda_oe && !wr_valid && !rd_valid, "R1 in reset", {sda_oe, wr_valid, rd_valid}, 0);
    rst_n = 1'b1;
    wt(3);
    chk(!sda_oe && !wr_valid && !rd_valid, "R1 after reset", {sda_oe, wr_valid, rd_valid}, 0);

    // R2 R4 R5: write run across index 31, address bit 0 set
    start_c();
    send({ADDR, 1'b1}, a); chk(a, "R2 address ack", a, 1);
    send(cmd(1'b1, 1'b0, 5'd30, 1'b0), a); chk(a, "R4 command ack", a, 1);
    push_wr(1'b0, 5'd30, 8'hA1); send(8'hA1, a); chk(a, "R5 data ack", a, 1);
    push_wr(1'b0, 5'd31, 8'hB2); send(8'hB2, a); chk(a, "R5 data ack", a, 1);
    push_wr(1'b0, 5'd0,  8'hC3); send(8'hC3, a); chk(a, "R5 wrap ack", a, 1);
    stop_c();
    drain("R5 writes done");

    // R4 RAM bank
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b1, 5'd1, 1'b0), a); chk(a, "R4 ram command ack", a, 1);
    push_wr(1'b1, 5'd1, 8'h5E); send(8'h5E, a); chk(a, "R4 ram data ack", a, 1);
    stop_c();
    drain("R4 ram write done");

    // R6 writes blocked
    base = wr_seen;
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b0, 1'b1, 5'd4, 1'b0), a); chk(a, "R6 command ack", a, 1);
    send(8'h11, a); chk(a, "R6 blocked data ack", a, 1);
    send(8'h22, a); chk(a, "R6 blocked data ack", a, 1);
    stop_c();
    wt(20);
    chk(wr_seen == base, "R6 no write", wr_seen - base, 0);

    // R3 address mismatch
    base = wr_seen;
    quiet = 1'b1; quiet_viol = 0;
    start_c();
    send({7'h51, 1'b0}, a); chk(!a, "R3 mismatch nack", a, 0);
    send(cmd(1'b1, 1'b0, 5'd2, 1'b0), a); chk(!a, "R3 ignored byte nack", a, 0);
    send(8'h77, a); chk(!a, "R3 ignored byte nack", a, 0);
    stop_c();
    wt(20);
    quiet = 1'b0;
    chk(quiet_viol == 0, "R3 sda released", quiet_viol, 0);
    chk(wr_seen == base && !rd_valid, "R3 no request", wr_seen - base, 0);

    // R7 read run across index 31, master NACK ends it
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b1, 5'd30, 1'b1), a); chk(a, "R7 read command ack", a, 1);
    recv(v, 1'b1); chk(v == reg_val(1'b1, 5'd30), "R7 read byte0", v, reg_val(1'b1, 5'd30));
    recv(v, 1'b1); chk(v == reg_val(1'b1, 5'd31), "R7 read byte1", v, reg_val(1'b1, 5'd31));
    recv(v, 1'b0); chk(v == reg_val(1'b1, 5'd0),  "R7 read wrap", v, reg_val(1'b1, 5'd0));
    quiet = 1'b1; quiet_viol = 0;
    bit_in(a); bit_in(a);
    quiet = 1'b0;
    chk(quiet_viol == 0, "R7 released after nack", quiet_viol, 0);
    stop_c();

    // R8 stop mid-byte
    base = wr_seen;
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b0, 5'd7, 1'b0), a);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    stop_c();
    wt(20);
    chk(wr_seen == base, "R8 partial byte dropped", wr_seen - base, 0);
    start_c();
    send({ADDR, 1'b0}, a); chk(a, "R8 next transfer ack", a, 1);
    send(cmd(1'b1, 1'b0, 5'd7, 1'b0), a);
    push_wr(1'b0, 5'd7, 8'h3D); send(8'h3D, a); chk(a, "R8 next data ack", a, 1);
    stop_c();
    drain("R8 next write done");

    // R9 write back-pressure
    @(posedge clk); #1 wr_ready = 1'b0;
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b0, 5'd10, 1'b0), a);
    push_wr(1'b0, 5'd10, 8'h9A); send(8'h9A, a); chk(a, "R9 first byte ack", a, 1);
    send(8'h9B, a); chk(!a, "R9 blocked byte nack", a, 0);
    chk(wr_valid && wr_data == 8'h9A && wr_index == 5'd10, "R9 payload held", {wr_valid, wr_index, wr_data}, {1'b1, 5'd10, 8'h9A});
    @(posedge clk); #1 wr_ready = 1'b1;
    push_wr(1'b0, 5'd11, 8'h9C); send(8'h9C, a); chk(a, "R9 index not advanced ack", a, 1);
    stop_c();
    drain("R9 writes done");

    // R11 repeated start from write into read
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b0, 5'd2, 1'b0), a);
    push_wr(1'b0, 5'd2, 8'h44); send(8'h44, a);
    start_c();
    send({ADDR, 1'b0}, a); chk(a, "R11 address after restart", a, 1);
    send(cmd(1'b1, 1'b0, 5'd2, 1'b1), a);
    recv(v, 1'b0); chk(v == reg_val(1'b0, 5'd2), "R11 read after restart", v, reg_val(1'b0, 5'd2));
    stop_c();
    drain("R11 write done");

    // R10 late read answer gives 0xFF
    @(posedge clk); #1 rd_ready = 1'b0;
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b0, 5'd9, 1'b1), a);
    recv(v, 1'b0); chk(v == 8'hFF, "R10 late fetch byte", v, 8'hFF);
    stop_c();
    chk(rd_valid && rd_index == 5'd10, "R10 request held", {rd_valid, rd_index}, {1'b1, 5'd10});
    @(posedge clk); #1 rd_ready = 1'b1;
    wt(4);
    chk(!rd_valid, "R10 request accepted", rd_valid, 0);
    start_c();
    send({ADDR, 1'b0}, a);
    send(cmd(1'b1, 1'b0, 5'd9, 1'b1), a);
    recv(v, 1'b0); chk(v == reg_val(1'b0, 5'd9), "R10 timely fetch byte", v, reg_val(1'b0, 5'd9));
    stop_c();

    wt(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule